// File: doc/BRIEF.md
# Block Copy DMA Engine

This engine copies a contiguous run of 32-bit words between a local word-addressed SRAM and a host memory port, in either direction. Software programs it through a small 32-bit register window: a local base, a host base, a transfer length and a control register. A write to the control register starts the copy, and a sticky completion flag in a status register reports the end. The same flag drives a level interrupt output.

The copy runs one word at a time. A single-word read goes to the source port, and the engine waits for its response. It then issues a single-word write to the destination port and steps both pointers on. Each memory port is a plain valid/ready request channel with a separate response-valid strobe for read data. The sequencer has four states. `S_IDLE` waits for a start and goes to `S_FETCH` on a start. `S_FETCH` presents the source read and goes to `S_WAIT` when the request is accepted. `S_WAIT` holds for read data and goes to `S_STORE` on the response strobe. `S_STORE` presents the destination write. On acceptance it returns to `S_FETCH` while words remain, or to `S_IDLE` after the last word.

Top module: `blk_dma`

## Requirements
- R1: After reset every register reads 0, `irq` is low and neither memory port presents a request.
- R2: Register map, at byte offsets on `reg_addr`: local base 0x50, host base 0x54, length 0x58, control 0x5C, status 0x94. The local base keeps bits LOC_AW+1:2 only, so writing all ones reads back 0x00003FFC by default. The host base keeps all 32 bits. The length keeps bits SIZE_W-1:0, so writing all ones reads 0x0000FFFF by default. Any other offset reads 0.
- R3: The control register keeps only bits 9, 1 and 0. Writing 0xFFFFFFFF reads back 0x00000203, and writing 0 reads back 0.
- R4: A control write while idle starts a copy of (length>>2)+1 words, so a length of 0 moves exactly one word. Words past the end of the range are left untouched.
- R5: Control bit 0 of the starting write selects the direction: 1 copies local to host, and 0 copies host to local. Each word is read from the source before it is written to the destination, and only one port has a request pending at a time.
- R6: The local port address is a word address that starts at the local base divided by 4 and steps by 1. The host port address is a byte address that starts at the host base and steps by 4.
- R7: Status bit 5 (complete) becomes 1 on the clock edge that accepts the last destination write. It stays 0 during the copy. `irq` follows this bit.
- R8: Writing a 1 to status bit 5 clears it. Writing 0 to that bit leaves it unchanged. If a clear and a completion land on the same edge, the completion wins.
- R9: A control write during a copy updates the stored control bits but neither restarts the copy nor changes its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt, equal to the complete flag |
| loc_req_valid | output | 1 | Local request valid |
| loc_req_write | output | 1 | Local request is a write |
| loc_req_addr | output | LOC_AW | Local word address |
| loc_req_wdata | output | 32 | Local write data |
| loc_req_ready | input | 1 | Local request accepted |
| loc_rsp_valid | input | 1 | Local read data valid |
| loc_rsp_rdata | input | 32 | Local read data |
| host_req_valid | output | 1 | Host request valid |
| host_req_write | output | 1 | Host request is a write |
| host_req_addr | output | 32 | Host byte address |
| host_req_wdata | output | 32 | Host write data |
| host_req_ready | input | 1 | Host request accepted |
| host_rsp_valid | input | 1 | Host read data valid |
| host_rsp_rdata | input | 32 | Host read data |

## Verification
The assertions check four things on every cycle:
- only the control mask bits are ever stored;
- the complete flag rises only on the edge after a last-word write, and holds until a 1 is written to it;
- a start is only honoured while the sequencer is idle;
- only one port requests at a time, and the word counter moves only on a write.

Other behaviour can only be shown by the bench's scenarios. Those scenarios cover: which memory words end up holding which data in each direction, that a length of 0 moves a single word, that the word after the range is untouched, the read-back masks, and that a control write during a copy leaves the copy's direction unchanged and starts no second copy. Both memory models stall their ready lines in a fixed pseudo-random pattern.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam logic [7:0]  OFS_LBASE = 8'h50;
    localparam logic [7:0]  OFS_HBASE = 8'h54;
    localparam logic [7:0]  OFS_SIZE  = 8'h58;
    localparam logic [7:0]  OFS_CTL   = 8'h5C;
    localparam logic [7:0]  OFS_STAT  = 8'h94;
    localparam logic [31:0] CTL_KEEP  = 32'h0000_0203;
    localparam int          DIR_BIT   = 0;
    localparam int          CMP_BIT   = 5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_WAIT,
        S_STORE
    } seq_state_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int LOC_AW = 12,
    parameter int SIZE_W = 16,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              xfer_done,
    output logic [LOC_AW-1:0] lbase,
    output logic [31:0]       hbase,
    output logic [SIZE_W-1:0] size,
    output logic              start,
    output logic              start_dir,
    output logic              irq
);
    localparam logic [REG_AW-1:0] A_LB = REG_AW'(OFS_LBASE);
    localparam logic [REG_AW-1:0] A_HB = REG_AW'(OFS_HBASE);
    localparam logic [REG_AW-1:0] A_SZ = REG_AW'(OFS_SIZE);
    localparam logic [REG_AW-1:0] A_CT = REG_AW'(OFS_CTL);
    localparam logic [REG_AW-1:0] A_ST = REG_AW'(OFS_STAT);

    logic [LOC_AW-1:0] lbase_q;
    logic [31:0]       hbase_q;
    logic [SIZE_W-1:0] size_q;
    logic [31:0]       ctl_q;
    logic              cmp_q;
    logic              wr_lb, wr_hb, wr_sz, wr_ct, wr_st;

    assign wr_lb = reg_wr && (reg_addr == A_LB);
    assign wr_hb = reg_wr && (reg_addr == A_HB);
    assign wr_sz = reg_wr && (reg_addr == A_SZ);
    assign wr_ct = reg_wr && (reg_addr == A_CT);
    assign wr_st = reg_wr && (reg_addr == A_ST);

    assign start     = wr_ct && !busy;
    assign start_dir = reg_wdata[DIR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lbase_q <= '0;
            hbase_q <= '0;
            size_q  <= '0;
            ctl_q   <= '0;
            cmp_q   <= 1'b0;
        end else begin
            if (wr_lb) lbase_q <= reg_wdata[LOC_AW+1:2];
            if (wr_hb) hbase_q <= reg_wdata;
            if (wr_sz) size_q  <= reg_wdata[SIZE_W-1:0];
            if (wr_ct) ctl_q   <= reg_wdata & CTL_KEEP;
            if (xfer_done)
                cmp_q <= 1'b1;
            else if (wr_st && reg_wdata[CMP_BIT])
                cmp_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_LB:    reg_rdata = 32'({lbase_q, 2'b00});
            A_HB:    reg_rdata = hbase_q;
            A_SZ:    reg_rdata = 32'(size_q);
            A_CT:    reg_rdata = ctl_q;
            A_ST:    reg_rdata = 32'(cmp_q) << CMP_BIT;
            default: reg_rdata = '0;
        endcase
    end

    assign lbase = lbase_q;
    assign hbase = hbase_q;
    assign size  = size_q;
    assign irq   = cmp_q;

    AST_CTL_ONLY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & ~CTL_KEEP) == 32'h0); // R3

    AST_CMP_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_q) |-> $past(xfer_done)); // R7

    AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q && !(wr_st && reg_wdata[CMP_BIT])) |=> cmp_q); // R8
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int LOC_AW = 12,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_dir,
    input  logic [LOC_AW-1:0] lbase,
    input  logic [31:0]       hbase,
    input  logic [SIZE_W-1:0] size,
    output logic              busy,
    output logic              xfer_done,
    output logic              loc_req_valid,
    output logic              loc_req_write,
    output logic [LOC_AW-1:0] loc_req_addr,
    output logic [31:0]       loc_req_wdata,
    input  logic              loc_req_ready,
    input  logic              loc_rsp_valid,
    input  logic [31:0]       loc_rsp_rdata,
    output logic              host_req_valid,
    output logic              host_req_write,
    output logic [31:0]       host_req_addr,
    output logic [31:0]       host_req_wdata,
    input  logic              host_req_ready,
    input  logic              host_rsp_valid,
    input  logic [31:0]       host_rsp_rdata
);
    localparam int CNT_W = SIZE_W - 2;

    seq_state_t        state_q, state_d;
    logic              dir_q;
    logic [LOC_AW-1:0] lptr_q;
    logic [31:0]       hptr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [31:0]       data_q;
    logic              src_ready, src_rsp, dst_ready;
    logic [31:0]       src_rdata;
    logic              last_word;

    assign src_ready = dir_q ? loc_req_ready  : host_req_ready;
    assign dst_ready = dir_q ? host_req_ready : loc_req_ready;
    assign src_rsp   = dir_q ? loc_rsp_valid  : host_rsp_valid;
    assign src_rdata = dir_q ? loc_rsp_rdata  : host_rsp_rdata;
    assign last_word = (remain_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start)     state_d = S_FETCH;
            S_FETCH: if (src_ready) state_d = S_WAIT;
            S_WAIT:  if (src_rsp)   state_d = S_STORE;
            S_STORE: if (dst_ready) state_d = last_word ? S_IDLE : S_FETCH;
            default:                state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= 1'b0;
            lptr_q   <= '0;
            hptr_q   <= '0;
            remain_q <= '0;
            data_q   <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                dir_q    <= start_dir;
                lptr_q   <= lbase;
                hptr_q   <= hbase;
                remain_q <= size[SIZE_W-1:2];
            end
            if (state_q == S_WAIT && src_rsp)
                data_q <= src_rdata;
            if (state_q == S_STORE && dst_ready && !last_word) begin
                lptr_q   <= lptr_q + 1'b1;
                hptr_q   <= hptr_q + 32'd4;
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    always_comb begin
        busy           = (state_q != S_IDLE);
        xfer_done      = (state_q == S_STORE) && dst_ready && last_word;
        loc_req_valid  = 1'b0;
        host_req_valid = 1'b0;
        loc_req_write  = 1'b0;
        host_req_write = 1'b0;
        unique case (state_q)
            S_FETCH: begin
                loc_req_valid  = dir_q;
                host_req_valid = !dir_q;
            end
            S_STORE: begin
                loc_req_valid  = !dir_q;
                host_req_valid = dir_q;
                loc_req_write  = !dir_q;
                host_req_write = dir_q;
            end
            default: ;
        endcase
        loc_req_addr   = lptr_q;
        loc_req_wdata  = data_q;
        host_req_addr  = hptr_q;
        host_req_wdata = data_q;
    end

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_req_valid && host_req_valid)); // R5

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == S_IDLE)); // R9

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH || state_q == S_WAIT) |=> $stable(remain_q)); // R4

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_req_write || host_req_write) |-> $past(state_q == S_WAIT && src_rsp)); // R5
endmodule

// File: rtl/blk_dma.sv
module blk_dma
    import dma_pkg::*;
#(
    parameter int LOC_AW = 12,
    parameter int SIZE_W = 16,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              loc_req_valid,
    output logic              loc_req_write,
    output logic [LOC_AW-1:0] loc_req_addr,
    output logic [31:0]       loc_req_wdata,
    input  logic              loc_req_ready,
    input  logic              loc_rsp_valid,
    input  logic [31:0]       loc_rsp_rdata,
    output logic              host_req_valid,
    output logic              host_req_write,
    output logic [31:0]       host_req_addr,
    output logic [31:0]       host_req_wdata,
    input  logic              host_req_ready,
    input  logic              host_rsp_valid,
    input  logic [31:0]       host_rsp_rdata
);
    logic              busy, xfer_done, start, start_dir;
    logic [LOC_AW-1:0] lbase;
    logic [31:0]       hbase;
    logic [SIZE_W-1:0] size;

    dma_regs #(.LOC_AW(LOC_AW), .SIZE_W(SIZE_W), .REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .xfer_done (xfer_done),
        .lbase     (lbase),
        .hbase     (hbase),
        .size      (size),
        .start     (start),
        .start_dir (start_dir),
        .irq       (irq)
    );

    dma_seq #(.LOC_AW(LOC_AW), .SIZE_W(SIZE_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .start_dir      (start_dir),
        .lbase          (lbase),
        .hbase          (hbase),
        .size           (size),
        .busy           (busy),
        .xfer_done      (xfer_done),
        .loc_req_valid  (loc_req_valid),
        .loc_req_write  (loc_req_write),
        .loc_req_addr   (loc_req_addr),
        .loc_req_wdata  (loc_req_wdata),
        .loc_req_ready  (loc_req_ready),
        .loc_rsp_valid  (loc_rsp_valid),
        .loc_rsp_rdata  (loc_rsp_rdata),
        .host_req_valid (host_req_valid),
        .host_req_write (host_req_write),
        .host_req_addr  (host_req_addr),
        .host_req_wdata (host_req_wdata),
        .host_req_ready (host_req_ready),
        .host_rsp_valid (host_rsp_valid),
        .host_rsp_rdata (host_rsp_rdata)
    );
endmodule

// File: tb/test_blk_dma.sv
module test_blk_dma;
    localparam int LOC_AW = 12;
    localparam logic [7:0] A_LB = 8'h50, A_HB = 8'h54, A_SZ = 8'h58, A_CT = 8'h5C, A_ST = 8'h94;

    typedef struct packed {
        logic        dir;
        logic [31:0] lb;
        logic [31:0] hb;
        logic [31:0] sz;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        '{1'b0, 32'h0000_0010, 32'h0000_0040, 32'h0000_001C},
        '{1'b1, 32'h0000_0023, 32'h0000_0080, 32'h0000_000C},
        '{1'b0, 32'h0000_0080, 32'h0000_0004, 32'h0000_003C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq;
    logic loc_req_valid, loc_req_write, host_req_valid, host_req_write;
    logic [LOC_AW-1:0] loc_req_addr;
    logic [31:0] loc_req_wdata, host_req_addr, host_req_wdata;
    logic loc_req_ready = 1'b0, host_req_ready = 1'b0;
    logic loc_rsp_valid = 1'b0, host_rsp_valid = 1'b0;
    logic [31:0] loc_rsp_rdata = '0, host_rsp_rdata = '0;

    int total = 0;
    int bad = 0;
    logic fill_req = 1'b0;
    logic [31:0] lmem [64];
    logic [31:0] hmem [64];

    always #2.5 clk = ~clk;

    blk_dma i_blk_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .loc_req_valid(loc_req_valid), .loc_req_write(loc_req_write),
        .loc_req_addr(loc_req_addr), .loc_req_wdata(loc_req_wdata),
        .loc_req_ready(loc_req_ready), .loc_rsp_valid(loc_rsp_valid),
        .loc_rsp_rdata(loc_rsp_rdata),
        .host_req_valid(host_req_valid), .host_req_write(host_req_write),
        .host_req_addr(host_req_addr), .host_req_wdata(host_req_wdata),
        .host_req_ready(host_req_ready), .host_rsp_valid(host_rsp_valid),
        .host_rsp_rdata(host_rsp_rdata)
    );

    function automatic logic [31:0] lpat(int i);
        return 32'hA500_0000 | 32'(i);
    endfunction
    function automatic logic [31:0] hpat(int i);
        return 32'h5A00_0000 | (32'(i) << 8);
    endfunction

    // Memory models: act at negedge on what the previous posedge accepted
    logic [15:0] lfsr = 16'hACE1;
    logic l_acc = 1'b0, l_wr = 1'b0, h_acc = 1'b0, h_wr = 1'b0;
    logic [5:0] l_idx = '0, h_idx = '0;
    logic [31:0] l_wd = '0, h_wd = '0;
    always @(negedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 64; i++) begin
                lmem[i] = lpat(i);
                hmem[i] = hpat(i);
            end
        end
        loc_rsp_valid = 1'b0;
        host_rsp_valid = 1'b0;
        if (l_acc) begin
            if (l_wr) lmem[l_idx] = l_wd;
            else begin loc_rsp_valid = 1'b1; loc_rsp_rdata = lmem[l_idx]; end
        end
        if (h_acc) begin
            if (h_wr) hmem[h_idx] = h_wd;
            else begin host_rsp_valid = 1'b1; host_rsp_rdata = hmem[h_idx]; end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        loc_req_ready  = lfsr[0] | lfsr[4];
        host_req_ready = lfsr[2] | lfsr[7];
        l_acc = loc_req_valid && loc_req_ready;
        l_wr  = loc_req_write;
        l_idx = loc_req_addr[5:0];
        l_wd  = loc_req_wdata;
        h_acc = host_req_valid && host_req_ready;
        h_wr  = host_req_write;
        h_idx = host_req_addr[7:2];
        h_wd  = host_req_wdata;
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(output logic ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int n = 0; n < 3000 && !ok; n++) begin
            rd(A_ST, v);
            ok = v[5];
        end
    endtask

    task automatic do_fill();
        @(negedge clk);
        fill_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1 fill_req = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        logic ok;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_LB, v); check(v == 0, "R1 lbase", v, 0);
        rd(A_HB, v); check(v == 0, "R1 hbase", v, 0);
        rd(A_SZ, v); check(v == 0, "R1 size", v, 0);
        rd(A_CT, v); check(v == 0, "R1 ctl", v, 0);
        rd(A_ST, v); check(v == 0, "R1 status", v, 0);
        check(!irq && !loc_req_valid && !host_req_valid, "R1 idle outputs",
              {29'b0, irq, loc_req_valid, host_req_valid}, 0);

        // R2: masks and unmapped offsets
        wr(A_LB, 32'hFFFF_FFFF); rd(A_LB, v); check(v == 32'h3FFC, "R2 lbase mask", v, 32'h3FFC);
        wr(A_HB, 32'hFFFF_FFFF); rd(A_HB, v); check(v == 32'hFFFF_FFFF, "R2 hbase full", v, 32'hFFFF_FFFF);
        wr(A_SZ, 32'hFFFF_FFFF); rd(A_SZ, v); check(v == 32'hFFFF, "R2 size mask", v, 32'hFFFF);
        wr(8'h60, 32'h1234_5678); rd(8'h60, v); check(v == 0, "R2 unmapped 60", v, 0);
        rd(8'h90, v); check(v == 0, "R2 unmapped 90", v, 0);
        wr(A_LB, 0); wr(A_HB, 0); wr(A_SZ, 0);

        // R3: control mask (each write also starts a one-word copy)
        do_fill();
        wr(A_CT, 32'hFFFF_FFFF); rd(A_CT, v); check(v == 32'h203, "R3 ctl all ones", v, 32'h203);
        wait_done(ok); check(ok, "R3 copy after ones", {31'b0, ok}, 1);
        wr(A_ST, 32'h20);
        wr(A_CT, 32'h0); rd(A_CT, v); check(v == 0, "R3 ctl all zeros", v, 0);
        wait_done(ok); check(ok, "R3 copy after zeros", {31'b0, ok}, 1);
        wr(A_ST, 32'h20);

        // R4 R5 R6 R7: vector table
        foreach (VEC[k]) begin
            int n, li, hi, errs;
            do_fill();
            n  = int'(VEC[k].sz >> 2) + 1;
            li = int'(VEC[k].lb >> 2) & 63;
            hi = int'(VEC[k].hb >> 2) & 63;
            wr(A_LB, VEC[k].lb); wr(A_HB, VEC[k].hb); wr(A_SZ, VEC[k].sz);
            wr(A_CT, 32'h200 | 32'(VEC[k].dir));
            if (n > 1) begin
                rd(A_ST, v); check(v == 0 && !irq, "R7 flag clear while busy", v, 0);
            end
            wait_done(ok); check(ok, "R7 complete flag set", {31'b0, ok}, 1);
            check(irq, "R7 irq high", {31'b0, irq}, 1);
            errs = 0;
            for (int j = 0; j < n; j++) begin
                if (VEC[k].dir) errs += (hmem[hi + j] != lpat(li + j)) ? 1 : 0;
                else            errs += (lmem[li + j] != hpat(hi + j)) ? 1 : 0;
            end
            check(errs == 0, "R5 R6 copied words", errs, 0);
            if (VEC[k].dir) begin
                check(hmem[hi + n] == hpat(hi + n), "R4 word past end", hmem[hi + n], hpat(hi + n));
                check(lmem[li] == lpat(li), "R5 source intact", lmem[li], lpat(li));
            end else begin
                check(lmem[li + n] == lpat(li + n), "R4 word past end", lmem[li + n], lpat(li + n));
                check(hmem[hi] == hpat(hi), "R5 source intact", hmem[hi], hpat(hi));
            end
            wr(A_ST, 32'h20);
        end

        // R8: write-one-to-clear
        wr(A_LB, 0); wr(A_HB, 0); wr(A_SZ, 0); wr(A_CT, 32'h201);
        wait_done(ok);
        wr(A_ST, 32'h0); rd(A_ST, v); check(v == 32'h20 && irq, "R8 write 0 keeps flag", v, 32'h20);
        wr(A_ST, 32'hFFFF_FFDF); rd(A_ST, v); check(v == 32'h20, "R8 other bits keep flag", v, 32'h20);
        wr(A_ST, 32'h20); rd(A_ST, v); check(v == 0 && !irq, "R8 write 1 clears", v, 0);

        // R9: control write while busy
        do_fill();
        wr(A_SZ, 32'h3C); wr(A_CT, 32'h201);
        wr(A_CT, 32'h200);
        rd(A_CT, v); check(v == 32'h200, "R9 ctl updated while busy", v, 32'h200);
        wait_done(ok); check(ok, "R9 copy finishes", {31'b0, ok}, 1);
        begin
            int errs = 0;
            for (int j = 0; j < 16; j++) errs += (hmem[j] != lpat(j) || lmem[j] != lpat(j)) ? 1 : 0;
            check(errs == 0, "R9 direction kept", errs, 0);
        end
        wr(A_ST, 32'h20);
        repeat (60) @(posedge clk);
        rd(A_ST, v); check(v == 0, "R9 no restart", v, 0);
        check(!loc_req_valid && !host_req_valid, "R9 idle after copy",
              {30'b0, loc_req_valid, host_req_valid}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule